// File: doc/BRIEF.md
# Branch and Jump Next-PC Selector

This block computes the address of the next instruction for a single-cycle processor. It takes the current PC, the sign-extended 16-bit immediate, the 26-bit jump field, the two source register values and the decoded control signals. From these it produces the next PC. It decides branch conditions itself, so it needs no zero flag or compare result from the ALU.

The block is purely combinational. The PC register and the register file belong to the surrounding datapath. The block also supplies the return address (PC + 4) and a write strobe for register 31, which the datapath uses for jump-and-link. A test wrapper can close the loop by feeding `next_pc_o` back into a PC register.

Top module: `npc_unit`

## Requirements
- R1: When no branch is taken and no jump control is set, `next_pc_o` equals `pc_i + 4` modulo 2^32. After an active-low reset, a PC register fed from this output starts at 0 and then advances by 4 each cycle.
- R2: Branch kind 1 (equal) is taken when `rs_val_i == rt_val_i`. A taken branch gives `next_pc_o = pc_i + 4 + (imm_i << 2)` modulo 2^32.
- R3: Branch kind 2 (nonzero) is taken when `rs_val_i != 0`, whatever the value of `rt_val_i`.
- R4: Branch kind 3 (less-or-equal) is taken when `rs_val_i <= rt_val_i`, with both compared as signed two's-complement numbers.
- R5: Branch kind 4 (negative) is taken exactly when bit 31 of `rs_val_i` is 1.
- R6: Branch kind 0, and the unused kinds 5 to 7, are never taken. A branch that is not taken gives `pc_i + 4`.
- R7: When `jump_i` or `link_i` is set and `jreg_i` is clear, `next_pc_o = {pc_i[31:28], jaddr_i, 2'b00}`.
- R8: `link_we_o` follows `link_i`. On jump-and-link, the return value `link_val_o` is `pc_i + 4`.
- R9: `jreg_i` makes `next_pc_o` equal the full value of `rs_val_i`. It overrides every other control input.
- R10: A region jump takes precedence over a taken branch.
- R11: `link_val_o` always equals `pc_i + 4` modulo 2^32, including when the PC wraps at 0xFFFFFFFC.
- R12: `br_taken_o` reports the condition of the selected branch kind. Its value does not depend on the jump controls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 32 | Current program counter |
| imm_i | input | 32 | Sign-extended immediate (word offset) |
| jaddr_i | input | 26 | Jump target field |
| rs_val_i | input | 32 | First source register value |
| rt_val_i | input | 32 | Second source register value |
| br_kind_i | input | 3 | Branch kind: 0 none, 1 equal, 2 nonzero, 3 less-or-equal, 4 negative |
| jump_i | input | 1 | Region-absolute jump |
| link_i | input | 1 | Jump-and-link (region jump plus write of register 31) |
| jreg_i | input | 1 | Jump to the address held in rs |
| next_pc_o | output | 32 | Selected next PC |
| link_val_o | output | 32 | Return address (PC + 4) |
| link_we_o | output | 1 | Write strobe for register 31 |
| br_taken_o | output | 1 | Branch condition met |

## Verification
The block holds no state, so a fault in the selection or compare logic appears on `next_pc_o` in the same cycle as the stimulus. A bench PC register fed from that output then carries the wrong address into every later cycle. Signed compare faults only show up in particular cases: operands of opposite sign, equal operands, and the value 0x80000000. For that reason, directed cases sit next to the random ones. A fault in priority only shows when several controls are asserted together, which both the random and the directed stimulus do.

// File: rtl/npc_pkg.sv
package npc_pkg;
  typedef enum logic [2:0] {
    BR_NONE = 3'd0,
    BR_EQ   = 3'd1,
    BR_NEZ  = 3'd2,
    BR_LE   = 3'd3,
    BR_LTZ  = 3'd4
  } br_kind_e;

  typedef enum logic [1:0] {
    SEL_SEQ = 2'd0,
    SEL_BR  = 2'd1,
    SEL_JMP = 2'd2,
    SEL_REG = 2'd3
  } npc_sel_e;
endpackage

// File: rtl/npc_targets.sv
module npc_targets #(
  parameter int XLEN     = 32,
  parameter int JADDR_W  = 26,
  parameter int WSHIFT   = 2
) (
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    imm_i,
  input  logic [JADDR_W-1:0] jaddr_i,
  output logic [XLEN-1:0]    seq_o,
  output logic [XLEN-1:0]    br_tgt_o,
  output logic [XLEN-1:0]    jmp_tgt_o
);
  localparam int REGION_W = XLEN - JADDR_W - WSHIFT;
  localparam logic [XLEN-1:0] STEP = XLEN'(1) << WSHIFT;

  assign seq_o     = pc_i + STEP;
  assign br_tgt_o  = seq_o + (imm_i << WSHIFT);
  assign jmp_tgt_o = {pc_i[XLEN-1 -: REGION_W], jaddr_i, {WSHIFT{1'b0}}};
endmodule

// File: rtl/npc_cond.sv
module npc_cond
  import npc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic [XLEN-1:0] rs_i,
  input  logic [XLEN-1:0] rt_i,
  input  logic [2:0]      kind_i,
  output logic            taken_o
);
  logic eq, nez, ltz, le;

  assign eq  = (rs_i == rt_i);
  assign nez = |rs_i;
  assign ltz = rs_i[XLEN-1];

  generate
    if (SIGNED_CMP) begin : g_signed
      assign le = ($signed(rs_i) <= $signed(rt_i));
    end else begin : g_unsigned
      assign le = (rs_i <= rt_i);
    end
  endgenerate

  always_comb begin
    unique case (kind_i)
      BR_EQ:   taken_o = eq;
      BR_NEZ:  taken_o = nez;
      BR_LE:   taken_o = le;
      BR_LTZ:  taken_o = ltz;
      default: taken_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/npc_select.sv
module npc_select
  import npc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic            jreg_i,
  input  logic            jmp_i,
  input  logic            taken_i,
  input  logic [XLEN-1:0] seq_i,
  input  logic [XLEN-1:0] br_tgt_i,
  input  logic [XLEN-1:0] jmp_tgt_i,
  input  logic [XLEN-1:0] reg_tgt_i,
  output logic [XLEN-1:0] next_o
);
  npc_sel_e sel;

  // fixed priority: register jump, region jump, branch, sequential
  always_comb begin
    if (jreg_i)       sel = SEL_REG;
    else if (jmp_i)   sel = SEL_JMP;
    else if (taken_i) sel = SEL_BR;
    else              sel = SEL_SEQ;
  end

  always_comb begin
    unique case (sel)
      SEL_REG: next_o = reg_tgt_i;
      SEL_JMP: next_o = jmp_tgt_i;
      SEL_BR:  next_o = br_tgt_i;
      default: next_o = seq_i;
    endcase
  end
endmodule

// File: rtl/npc_unit.sv
module npc_unit
  import npc_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int JADDR_W    = 26,
  parameter int WSHIFT     = 2,
  parameter bit SIGNED_CMP = 1'b1
) (
  input  logic [XLEN-1:0]    pc_i,
  input  logic [XLEN-1:0]    imm_i,
  input  logic [JADDR_W-1:0] jaddr_i,
  input  logic [XLEN-1:0]    rs_val_i,
  input  logic [XLEN-1:0]    rt_val_i,
  input  logic [2:0]         br_kind_i,
  input  logic               jump_i,
  input  logic               link_i,
  input  logic               jreg_i,
  output logic [XLEN-1:0]    next_pc_o,
  output logic [XLEN-1:0]    link_val_o,
  output logic               link_we_o,
  output logic               br_taken_o
);
  logic [XLEN-1:0] seq, br_tgt, jmp_tgt;
  logic            taken;

  npc_targets #(.XLEN(XLEN), .JADDR_W(JADDR_W), .WSHIFT(WSHIFT)) u_tgt (
    .pc_i      (pc_i),
    .imm_i     (imm_i),
    .jaddr_i   (jaddr_i),
    .seq_o     (seq),
    .br_tgt_o  (br_tgt),
    .jmp_tgt_o (jmp_tgt)
  );

  npc_cond #(.XLEN(XLEN), .SIGNED_CMP(SIGNED_CMP)) u_cond (
    .rs_i    (rs_val_i),
    .rt_i    (rt_val_i),
    .kind_i  (br_kind_i),
    .taken_o (taken)
  );

  npc_select #(.XLEN(XLEN)) u_sel (
    .jreg_i    (jreg_i),
    .jmp_i     (jump_i | link_i),
    .taken_i   (taken),
    .seq_i     (seq),
    .br_tgt_i  (br_tgt),
    .jmp_tgt_i (jmp_tgt),
    .reg_tgt_i (rs_val_i),
    .next_o    (next_pc_o)
  );

  assign link_val_o = seq;
  assign link_we_o  = link_i;
  assign br_taken_o = taken;
endmodule

// File: rtl/npc_unit_chk.sv
module npc_unit_chk (
  input logic [31:0] pc_i,
  input logic [31:0] imm_i,
  input logic [25:0] jaddr_i,
  input logic [31:0] rs_val_i,
  input logic [31:0] rt_val_i,
  input logic [2:0]  br_kind_i,
  input logic        jump_i,
  input logic        link_i,
  input logic        jreg_i,
  input logic [31:0] next_pc_o,
  input logic [31:0] link_val_o,
  input logic        link_we_o,
  input logic        br_taken_o
);
  always_comb begin
    // R11
    link_seq_chk: assert (link_val_o == pc_i + 32'd4);
    // R9
    jreg_tgt_chk: assert (!jreg_i || next_pc_o == rs_val_i);
    // R7
    region_tgt_chk: assert (jreg_i || !(jump_i || link_i) ||
                            next_pc_o == {pc_i[31:28], jaddr_i, 2'b00});
    // R2
    br_tgt_chk: assert (jreg_i || jump_i || link_i || !br_taken_o ||
                        next_pc_o == pc_i + 32'd4 + (imm_i << 2));
    // R6
    seq_tgt_chk: assert (jreg_i || jump_i || link_i || br_taken_o ||
                         next_pc_o == link_val_o);
    // R5
    ltz_cond_chk: assert (br_kind_i != 3'd4 || br_taken_o == rs_val_i[31]);
    // R4
    le_cond_chk: assert (br_kind_i != 3'd3 ||
                         br_taken_o == ($signed(rs_val_i) <= $signed(rt_val_i)));
    // R8
    link_we_chk: assert (link_we_o == link_i);
  end
endmodule

bind npc_unit npc_unit_chk u_chk (
  .pc_i       (pc_i),
  .imm_i      (imm_i),
  .jaddr_i    (jaddr_i),
  .rs_val_i   (rs_val_i),
  .rt_val_i   (rt_val_i),
  .br_kind_i  (br_kind_i),
  .jump_i     (jump_i),
  .link_i     (link_i),
  .jreg_i     (jreg_i),
  .next_pc_o  (next_pc_o),
  .link_val_o (link_val_o),
  .link_we_o  (link_we_o),
  .br_taken_o (br_taken_o)
);

// File: tb/npc_unit_test.sv
`timescale 1ns/1ps
module npc_unit_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0, imm_i = '0, rs_val_i = '0, rt_val_i = '0;
  logic [25:0] jaddr_i = '0;
  logic [2:0]  br_kind_i = '0;
  logic        jump_i = 1'b0, link_i = 1'b0, jreg_i = 1'b0;
  logic        use_reg = 1'b0;
  logic [31:0] next_pc_o, link_val_o, pc_q, pc_mux;
  logic        link_we_o, br_taken_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk or negedge rst_ni)
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= next_pc_o;

  assign pc_mux = use_reg ? pc_q : pc_i;

  npc_unit uut (
    .pc_i(pc_mux), .imm_i(imm_i), .jaddr_i(jaddr_i), .rs_val_i(rs_val_i),
    .rt_val_i(rt_val_i), .br_kind_i(br_kind_i), .jump_i(jump_i),
    .link_i(link_i), .jreg_i(jreg_i), .next_pc_o(next_pc_o),
    .link_val_o(link_val_o), .link_we_o(link_we_o), .br_taken_o(br_taken_o)
  );

  function automatic logic m_taken(logic [2:0] k, logic [31:0] rs, logic [31:0] rt);
    case (k)
      3'd1: return rs == rt;
      3'd2: return rs != 0;
      3'd3: return $signed(rs) <= $signed(rt);
      3'd4: return rs[31];
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_next(logic [31:0] pc, logic [31:0] imm,
      logic [25:0] ja, logic [31:0] rs, logic [31:0] rt, logic [2:0] k,
      logic j, logic l, logic jr);
    if (jr) return rs;
    if (j || l) return {pc[31:28], ja, 2'b00};
    if (m_taken(k, rs, rt)) return pc + 32'd4 + {imm[29:0], 2'b00};
    return pc + 32'd4;
  endfunction

  function automatic string m_tag(logic [2:0] k, logic j, logic l, logic jr, logic t);
    if (jr) return "R9";
    if (l) return "R8";
    if (j) return t ? "R10" : "R7";
    case (k)
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(logic [31:0] pc, logic [31:0] imm, logic [25:0] ja,
      logic [31:0] rs, logic [31:0] rt, logic [2:0] k, logic j, logic l, logic jr);
    logic t;
    @(negedge clk);
    pc_i = pc; imm_i = imm; jaddr_i = ja; rs_val_i = rs; rt_val_i = rt;
    br_kind_i = k; jump_i = j; link_i = l; jreg_i = jr;
    #1;
    t = m_taken(k, rs, rt);
    chk(m_tag(k, j, l, jr, t), next_pc_o, m_next(pc, imm, ja, rs, rt, k, j, l, jr));
    chk("R12", {31'd0, br_taken_o}, {31'd0, t});
    chk("R11", link_val_o, pc + 32'd4);
    chk("R8", {31'd0, link_we_o}, {31'd0, l});
  endtask

  initial begin
    while (cycles < 100000) begin
      @(posedge clk);
      cycles++;
    end
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1badcafe));
    use_reg = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", pc_q, 32'd0);
    rst_ni = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", pc_q, 32'd16);
    // jump through the register loop, then one sequential step
    jaddr_i = 26'h0000040; jump_i = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R7", pc_q, 32'h00000100);
    jump_i = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R1", pc_q, 32'h00000104);
    use_reg = 1'b0;

    // directed corners
    apply(32'hFFFFFFFC, 32'd0, 26'd0, 32'd0, 32'd0, 3'd0, 0, 0, 0);           // R11 wrap
    apply(32'h00001000, 32'hFFFFFFFF, 26'd0, 32'd7, 32'd7, 3'd1, 0, 0, 0);    // R2 backward
    apply(32'h00001000, 32'd3, 26'd0, 32'd7, 32'd8, 3'd1, 0, 0, 0);           // R2 not taken
    apply(32'h00002000, 32'd5, 26'd0, 32'd0, 32'd9, 3'd2, 0, 0, 0);           // R3 rs zero
    apply(32'h00002000, 32'd5, 26'd0, 32'd1, 32'd0, 3'd2, 0, 0, 0);           // R3 rs nonzero
    apply(32'h00003000, 32'd2, 26'd0, 32'd4, 32'd4, 3'd3, 0, 0, 0);           // R4 equal
    apply(32'h00003000, 32'd2, 26'd0, 32'hFFFFFFFF, 32'd1, 3'd3, 0, 0, 0);    // R4 neg<=pos
    apply(32'h00003000, 32'd2, 26'd0, 32'd1, 32'hFFFFFFFF, 3'd3, 0, 0, 0);    // R4 pos>neg
    apply(32'h00004000, 32'd1, 26'd0, 32'h80000000, 32'd0, 3'd4, 0, 0, 0);    // R5 min
    apply(32'h00004000, 32'd1, 26'd0, 32'd0, 32'd0, 3'd4, 0, 0, 0);           // R5 zero
    apply(32'h00004000, 32'd1, 26'd0, 32'd5, 32'd5, 3'd6, 0, 0, 0);           // R6 unused kind
    apply(32'hF0001234, 32'd0, 26'h3FFFFFF, 32'd0, 32'd0, 3'd0, 1, 0, 0);     // R7 region bits
    apply(32'hA0000010, 32'd0, 26'h0000123, 32'd0, 32'd0, 3'd0, 0, 1, 0);     // R8 link
    apply(32'h00005000, 32'd8, 26'h0000200, 32'd3, 32'd3, 3'd1, 1, 0, 0);     // R10
    apply(32'h00006000, 32'd8, 26'h0000200, 32'hDEADBEE0, 32'hDEADBEE0, 3'd1, 1, 1, 1); // R9

    // random stimulus
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] rs, rt, pc, imm;
      logic [2:0]  k;
      logic        j, l, jr;
      pc  = $urandom() & 32'hFFFFFFFC;
      imm = {{16{$urandom_range(0, 1) == 1}}, 16'($urandom())};
      rs  = $urandom();
      rt  = ($urandom_range(0, 3) == 0) ? rs : $urandom();
      if ($urandom_range(0, 5) == 0) rs = 32'd0;
      k   = 3'($urandom_range(0, 7));
      j   = ($urandom_range(0, 5) == 0);
      l   = ($urandom_range(0, 7) == 0);
      jr  = ($urandom_range(0, 9) == 0);
      apply(pc, imm, 26'($urandom()), rs, rt, k, j, l, jr);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule